// File: doc/BRIEF.md
# Clock Source Selection Sequencer

This block decides which clock feeds the core and in what order the clock controls change when the choice moves. It accepts a three-bit source request, a suspend event and a resume event, and turns each accepted request into a fixed series of register updates. Those updates drive a two-bit mux select, a divide-by-2 select and a request to reload a stored trim word into the second oscillator. The clock multiplexer cells and the oscillators themselves are outside the block. The block only sequences their selects and enables.

Moving to either mode of the second oscillator takes the long path. The core is first parked on the 26 MHz system clock, with the divider at 1. The block then asks for the trim word of the chosen mode and waits for a ready handshake. After a settle interval it writes the target divider, and one cycle later the final select. Every other source takes the short path, which is a divider write followed one cycle later by the select write.

Top module: `clksel_seq`

## Requirements
- R1: The request codes are 0 = system clock, 1 = 32 kHz, 2 = oscillator 1, 3 = oscillator 2 low speed and 4 = oscillator 2 high speed. `mux_sel` takes 0 for system, 1 for 32 kHz, 2 for oscillator 1 and 3 for either oscillator 2 mode.
- R2: `div2_sel` is 0 (divide by 1) after a switch to codes 0, 1, 2 or 4, and 1 (divide by 2) after a switch to code 3.
- R3: On every switch, the divider is written on the clock edge one cycle before the edge that writes `mux_sel`. `div2_sel` never changes on an edge where `mux_sel` changes.
- R4: For codes 3 and 4 the block first sets `div2_sel` to 0 (edge 1 after acceptance) and then `mux_sel` to 0 (edge 2), before it requests a trim reload.
- R5: After parking, `trim_reload` stays high until `trim_ready` is sampled high. During that time `trim_hi` is 0 for the low-speed mode and 1 for the high-speed mode.
- R6: After the edge that samples `trim_ready`, the block waits for CLK_MHZ*SETTLE_US cycles. It then writes the target divider, and on the next edge the final select.
- R7: Codes 5, 6 and 7 are treated as the system clock with divide by 1, and take the short path.
- R8: After a synchronous reset, `mux_sel` is 0, `div2_sel` is 0, and `busy` and `trim_reload` are both 0.
- R9: `busy` goes high on the edge that accepts a request and drops on the edge that writes the final select. While `busy` is high, requests and events have no effect.
- R10: `suspend_evt` requests the 32 kHz source and `resume_evt` requests oscillator 2 high speed. When several arrive together, suspend wins over resume, and resume wins over `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Source request strobe |
| req_src | input | 3 | Requested source code |
| suspend_evt | input | 1 | Suspend event; requests the 32 kHz source |
| resume_evt | input | 1 | Resume event; requests oscillator 2 high speed |
| trim_ready | input | 1 | Trim word reloaded into oscillator 2 |
| mux_sel | output | 2 | Clock multiplexer select |
| div2_sel | output | 1 | Post-divider select, 1 = divide by 2 |
| trim_reload | output | 1 | Request to reload oscillator 2 trim |
| trim_hi | output | 1 | Trim word to reload, 1 = high-speed mode |
| busy | output | 1 | A switch sequence is in progress |

## Verification
The bench builds the block with CLK_MHZ = 2 and SETTLE_US = 3, which gives a settle interval of 6 cycles. The default interval is 2500 cycles. With the short interval, every oscillator-2 switch finishes in a few dozen cycles, so the run can cover many different sequences. These include direct moves between the two oscillator-2 modes, fallback from every unknown code, and events that collide with each other. The trim handshake delay is varied from 1 to 5 cycles. Requests are injected while a switch is still parking or settling, which checks that they are ignored.

// File: rtl/clksel_pkg.sv
// Package clksel_pkg
// Shared encodings for the clock source selection sequencer.
// Assumes a three-bit request code and a four-way clock multiplexer.
package clksel_pkg;

    // Clock multiplexer select values
    typedef enum logic [1:0] {
        MUX_SYS  = 2'd0,
        MUX_32K  = 2'd1,
        MUX_OSC1 = 2'd2,
        MUX_OSC2 = 2'd3
    } mux_sel_e;

    // Request codes
    localparam logic [2:0] SRC_SYS     = 3'd0;
    localparam logic [2:0] SRC_32K     = 3'd1;
    localparam logic [2:0] SRC_OSC1    = 3'd2;
    localparam logic [2:0] SRC_OSC2_LO = 3'd3;
    localparam logic [2:0] SRC_OSC2_HI = 3'd4;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PARK_DIV,
        ST_PARK_SEL,
        ST_TRIM,
        ST_SETTLE,
        ST_DIV,
        ST_SEL
    } seq_state_e;

    // Decoded switch target
    typedef struct packed {
        mux_sel_e sel;
        logic     div2;
        logic     park;
        logic     trim_hi;
    } target_t;

endpackage

// File: rtl/clksel_arb.sv
// Module clksel_arb
// Picks which request to take this cycle: suspend, then resume, then a plain
// source request. Takes nothing unless the sequencer is idle.
// Assumes the events are single-cycle strobes. An event that arrives while
// the sequencer is busy is dropped, not held.
module clksel_arb (
    input  logic       idle,
    input  logic       req_valid,
    input  logic [2:0] req_src,
    input  logic       suspend_evt,
    input  logic       resume_evt,
    output logic       take,
    output logic [2:0] code
);
    import clksel_pkg::*;

    // Priority select of the winning request code
    always_comb begin
        if (suspend_evt)      code = SRC_32K;
        else if (resume_evt)  code = SRC_OSC2_HI;
        else                  code = req_src;
    end

    // A request is taken only when the sequencer is idle
    assign take = idle && (suspend_evt || resume_evt || req_valid);

endmodule

// File: rtl/clksel_decode.sv
// Module clksel_decode
// Maps a request code to the mux select, the divider, whether the switch must
// park and reload trim, and which trim word to reload.
// Assumes every code outside 0..4 falls back to the system clock.
module clksel_decode (
    input  logic [2:0]          code,
    output clksel_pkg::target_t tgt
);
    import clksel_pkg::*;

    // Target lookup per request code
    always_comb begin
        tgt = '{sel: MUX_SYS, div2: 1'b0, park: 1'b0, trim_hi: 1'b0};
        case (code)
            SRC_SYS:     tgt.sel = MUX_SYS;
            SRC_32K:     tgt.sel = MUX_32K;
            SRC_OSC1:    tgt.sel = MUX_OSC1;
            SRC_OSC2_LO: begin
                tgt.sel  = MUX_OSC2;
                tgt.div2 = 1'b1;
                tgt.park = 1'b1;
            end
            SRC_OSC2_HI: begin
                tgt.sel     = MUX_OSC2;
                tgt.park    = 1'b1;
                tgt.trim_hi = 1'b1;
            end
            default:     tgt.sel = MUX_SYS;
        endcase
    end

endmodule

// File: rtl/clksel_settle.sv
// Module clksel_settle
// Down-counter that times the settle interval after a trim reload.
// Loading it starts an interval of CYCLES ticks. done is high on the last tick.
// Assumes CYCLES >= 1 and that the sequencer ticks it only while it waits.
module clksel_settle #(
    parameter int CYCLES = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic done
);
    localparam int W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [W-1:0] LOAD_VAL = W'(CYCLES - 1);

    logic [W-1:0] cnt;

    // Count register: reload on start, count down while waiting
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (load)            cnt <= LOAD_VAL;
        else if (tick && cnt != 0) cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R6: the count never leaves the loaded range
    a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOAD_VAL);

    // R6: a tick that does not finish moves the count down by exactly one
    a_r6_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt != 0) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/clksel_seq.sv
// Module clksel_seq
// Clock source selection sequencer. It turns source requests and
// suspend/resume events into ordered writes of the divider and mux select.
// For oscillator 2 it first parks on the system clock, reloads trim and
// waits out a settle interval.
// Assumes the clock mux cells and the oscillators act on these selects
// outside this block.
module clksel_seq #(
    parameter int CLK_MHZ   = 50,
    parameter int SETTLE_US = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [2:0] req_src,
    input  logic       suspend_evt,
    input  logic       resume_evt,
    input  logic       trim_ready,
    output logic [1:0] mux_sel,
    output logic       div2_sel,
    output logic       trim_reload,
    output logic       trim_hi,
    output logic       busy
);
    import clksel_pkg::*;

    localparam int SETTLE_CYCLES = (CLK_MHZ * SETTLE_US > 0) ? CLK_MHZ * SETTLE_US : 1;

    seq_state_e state;
    mux_sel_e   mux_q;
    logic       div_q;
    logic       trim_hi_q;
    mux_sel_e   tgt_sel_q;
    logic       tgt_div_q;

    logic       take;
    logic [2:0] code;
    target_t    dec;
    logic       settle_done;

    clksel_arb u_arb (
        .idle        (state == ST_IDLE),
        .req_valid   (req_valid),
        .req_src     (req_src),
        .suspend_evt (suspend_evt),
        .resume_evt  (resume_evt),
        .take        (take),
        .code        (code)
    );

    clksel_decode u_dec (
        .code (code),
        .tgt  (dec)
    );

    clksel_settle #(.CYCLES(SETTLE_CYCLES)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state == ST_TRIM && trim_ready),
        .tick  (state == ST_SETTLE),
        .done  (settle_done)
    );

    // Sequencer state and the select and divider registers it owns
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mux_q     <= MUX_SYS;
            div_q     <= 1'b0;
            trim_hi_q <= 1'b0;
            tgt_sel_q <= MUX_SYS;
            tgt_div_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (take) begin
                    tgt_sel_q <= dec.sel;
                    tgt_div_q <= dec.div2;
                    if (dec.park) trim_hi_q <= dec.trim_hi;
                    state <= dec.park ? ST_PARK_DIV : ST_DIV;
                end
                ST_PARK_DIV: begin
                    div_q <= 1'b0;
                    state <= ST_PARK_SEL;
                end
                ST_PARK_SEL: begin
                    mux_q <= MUX_SYS;
                    state <= ST_TRIM;
                end
                ST_TRIM:   if (trim_ready)  state <= ST_SETTLE;
                ST_SETTLE: if (settle_done) state <= ST_DIV;
                ST_DIV: begin
                    div_q <= tgt_div_q;
                    state <= ST_SEL;
                end
                ST_SEL: begin
                    mux_q <= tgt_sel_q;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mux_sel     = mux_q;
    assign div2_sel    = div_q;
    assign trim_reload = (state == ST_TRIM);
    assign trim_hi     = trim_hi_q;
    assign busy        = (state != ST_IDLE);

    // R3: the divider never moves on the same edge as the select
    a_r3_div_before_sel: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mux_q) |-> $stable(div_q));

    // R4: oscillator 2 is only ever entered from the parked system clock
    a_r4_osc2_from_sys: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mux_q) && mux_q == MUX_OSC2) |-> $past(mux_q) == MUX_SYS);

    // R5: trim reload is requested only while parked on system clock at divide-by-1
    a_r5_reload_parked: assert property (@(posedge clk) disable iff (!rst_n)
        trim_reload |-> (mux_q == MUX_SYS && !div_q));

    // R2: at rest, every source other than oscillator 2 runs at divide-by-1
    a_r2_div1_at_rest: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mux_q != MUX_OSC2) |-> !div_q);

    // R9: a request seen while busy leaves the stored target untouched
    a_r9_busy_holds_target: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> ($stable(tgt_sel_q) && $stable(tgt_div_q)));

endmodule

// File: tb/clksel_seq_test.sv
// Bench for clksel_seq. A behavioural queue model of the expected writes is
// compared against every output on every falling edge.
module clksel_seq_test;
    localparam int CLK_MHZ   = 2;
    localparam int SETTLE_US = 3;
    localparam int SETTLE    = CLK_MHZ * SETTLE_US;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_src = 3'd0;
    logic       suspend_evt = 1'b0;
    logic       resume_evt = 1'b0;
    logic       trim_ready = 1'b0;
    logic [1:0] mux_sel;
    logic       div2_sel;
    logic       trim_reload;
    logic       trim_hi;
    logic       busy;

    clksel_seq #(.CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .suspend_evt(suspend_evt), .resume_evt(resume_evt), .trim_ready(trim_ready),
        .mux_sel(mux_sel), .div2_sel(div2_sel), .trim_reload(trim_reload),
        .trim_hi(trim_hi), .busy(busy)
    );

    always #10 clk = ~clk;

    int vectors = 0;
    int fails = 0;
    bit ended = 0;
    int trim_delay = 1;

    // Reference model: pending actions, coded kind*10+value
    // kinds: 1 divider write, 2 select write, 3 trim wait, 4 settle wait
    int q[$];
    int e_sel = 0, e_div = 0, e_thi = 0, wleft = 0;

    function automatic int sel_of(int c);
        case (c)
            1: return 1;
            2: return 2;
            3, 4: return 3;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            e_sel = 0; e_div = 0; e_thi = 0; wleft = 0;
        end else if (q.size() == 0) begin
            if (suspend_evt || resume_evt || req_valid) begin
                int c;
                c = suspend_evt ? 1 : (resume_evt ? 4 : int'(req_src));
                if (c == 3 || c == 4) begin
                    e_thi = (c == 4) ? 1 : 0;
                    q.push_back(10); q.push_back(20); q.push_back(30);
                    q.push_back(40);
                    q.push_back(10 + ((c == 3) ? 1 : 0));
                    q.push_back(20 + 3);
                end else begin
                    q.push_back(10);
                    q.push_back(20 + sel_of(c));
                end
            end
        end else begin
            int a;
            a = q[0];
            case (a / 10)
                1: begin e_div = a % 10; void'(q.pop_front()); end
                2: begin e_sel = a % 10; void'(q.pop_front()); end
                3: if (trim_ready) begin void'(q.pop_front()); wleft = SETTLE; end
                default: begin
                    wleft = wleft - 1;
                    if (wleft == 0) void'(q.pop_front());
                end
            endcase
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output on every falling edge after reset
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            chk("R1", "mux_sel", int'(mux_sel), e_sel);
            chk("R2", "div2_sel", int'(div2_sel), e_div);
            chk("R9", "busy", int'(busy), (q.size() != 0) ? 1 : 0);
            chk("R5", "trim_reload", int'(trim_reload), (q.size() != 0 && q[0] == 30) ? 1 : 0);
            chk("R5", "trim_hi", int'(trim_hi), e_thi);
        end
    end

    // Trim handshake responder with a programmable delay
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (trim_reload) begin
                cnt++;
                trim_ready = (cnt >= trim_delay);
            end else begin
                cnt = 0;
                trim_ready = 1'b0;
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 500) begin @(negedge clk); g++; end
        @(negedge clk);
    endtask

    task automatic request(input int c);
        @(negedge clk);
        req_valid = 1'b1; req_src = 3'(c);
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
    endtask

    task automatic events(input bit s, input bit r, input bit v, input int c);
        @(negedge clk);
        suspend_evt = s; resume_evt = r; req_valid = v; req_src = 3'(c);
        @(negedge clk);
        suspend_evt = 0; resume_evt = 0; req_valid = 0;
        wait_idle();
    endtask

    // Request, then hammer inputs for several cycles while the switch runs
    task automatic request_hammer(input int c, input int n);
        @(negedge clk);
        req_valid = 1'b1; req_src = 3'(c);
        @(negedge clk);
        req_src = 3'd1;
        for (int i = 0; i < n; i++) begin
            suspend_evt = i[0]; resume_evt = ~i[0];
            @(negedge clk);
        end
        req_valid = 0; suspend_evt = 0; resume_evt = 0;
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8", "reset mux_sel", int'(mux_sel), 0);
        chk("R8", "reset div2_sel", int'(div2_sel), 0);
        chk("R8", "reset busy", int'(busy), 0);
        chk("R8", "reset trim_reload", int'(trim_reload), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R3: short-path switches
        request(1);
        request(2);
        // R4 / R6: low-speed oscillator 2 with divide-by-2
        trim_delay = 1; request(3);
        // direct move between the oscillator 2 modes
        trim_delay = 4; request(4);
        trim_delay = 2; request(3);
        request(0);
        // R7: unknown codes fall back from different starting sources
        request(2); request(5);
        request(1); request(6);
        trim_delay = 3; request(4); request(7);
        // R10: events and their priority
        events(1, 0, 0, 0);
        trim_delay = 5; events(0, 1, 0, 0);
        events(1, 1, 1, 2);
        events(0, 1, 1, 2);
        events(0, 0, 1, 2);
        // R9: requests and events during a running switch are ignored
        trim_delay = 2; request_hammer(3, 12);
        request_hammer(0, 1);
        request_hammer(4, 8);
        // reset mid-sequence, R8 again
        @(negedge clk); req_valid = 1; req_src = 3'd3;
        @(negedge clk); req_valid = 0;
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk);
        chk("R8", "re-reset mux_sel", int'(mux_sel), 0);
        chk("R8", "re-reset busy", int'(busy), 0);
        rst_n = 1;
        request(2);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule